// File: doc/BRIEF.md
# Combinational Sum-of-Products Array

This block is a behavioural model of a small one-level programmable logic array of the kind found on a 20-pin logic device. Ten dedicated input pins and six bidirectional pins supply sixteen signals. Each signal enters the array both true and inverted, which gives 32 array columns. There are 64 product terms, each a programmable AND over any subset of the columns. The terms are split evenly across eight outputs. Within each group, one term drives that output's three-state enable. The other seven terms feed a fixed OR gate, and the OR result is inverted, so the output value is active-low.

The connection pattern is a static vector (`fuse_map`) presented before operation and held constant. A set bit means the column is connected to the product term. A fully intact, unprogrammed map connects every column, so every term is false. Pins are not modelled as tri-state nets. Each output has a value bus and an enable bus. The integrator resolves each bidirectional pin to its real level (the driven value when enabled, the external level otherwise) and returns that level on `pad_in`, which the array reads back.

Top module: `pal_sop_array`

## Requirements
- R1: Product term `t` (0..63) is the AND of the columns whose bit is set in `fuse_map[t*32 +: 32]`. Bit `2*s` selects signal `s` true and bit `2*s+1` selects it inverted. A term with no bit set evaluates to 1.
- R2: Signals 0 to 9 are `ded_in[0]` to `ded_in[9]`. Signals 10 to 15 are `pad_in[0]` to `pad_in[5]`.
- R3: A term that has both polarities of any signal connected is 0. The all-ones map therefore gives `out_en` = 8'h00 and `out_val` = 8'hFF for every input.
- R4: `out_en[o]` equals term `8*o`, the first term of group `o`, for every output. This includes the output-only pins 0 and 7.
- R5: `out_val[o]` is the inverse of the OR of terms `8*o+1` to `8*o+7`. The all-zero map gives `out_en` = 8'hFF and `out_val` = 8'h00.
- R6: `pad_in[b]` drives signal `10+b` whatever the state of `out_en[b+1]`. Bidirectional pin `b` is output `b+1`.
- R7: Both output buses depend only on the present inputs and map, with no retained state. The same inputs give the same outputs regardless of the inputs applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fuse_map | input | 2048 | Connection vector, 32 bits per product term, term 0 at the LSBs |
| ded_in | input | 10 | Dedicated input pins |
| pad_in | input | 6 | Resolved level of bidirectional pins 1 to 6 |
| out_val | output | 8 | Active-low output values, one per output pin |
| out_en | output | 8 | Three-state enables, one per output pin |

## Verification
The bound checker works on every input change. It checks that an enable term with no connections always enables its pin, and that an enable term holding a contradictory pair never does. It checks that any open sum term forces its output low, that seven contradictory sum terms force it high, and that the outputs never go unknown while the inputs are known. Only the bench scenarios can show the exact column order, including which pad feeds which signal. They also show that pad feedback is taken while the pin itself is enabled, that the outputs carry no memory of earlier inputs, and that the terms under partial, random programming match an independent evaluation of the map.

// File: rtl/pal_pkg.sv
// Package: default geometry of the array and index helpers shared by the
// array modules. Assumes column pairs are laid out true-then-inverted.
package pal_pkg;
    localparam int unsigned PAL_DED_IN = 10;
    localparam int unsigned PAL_BIDIR  = 6;
    localparam int unsigned PAL_OUTS   = 8;
    localparam int unsigned PAL_TPO    = 8;

    // First bit of a term's row inside the flat connection vector.
    function automatic int unsigned row_lsb(int unsigned term, int unsigned ncol);
        return term * ncol;
    endfunction

    // First term of an output's group.
    function automatic int unsigned group_lsb(int unsigned out_idx, int unsigned tpo);
        return out_idx * tpo;
    endfunction
endpackage

// File: rtl/pal_columns.sv
// Column builder: turns the dedicated inputs and resolved pad levels into
// true/inverted column pairs. Assumes pads follow the dedicated inputs in
// signal numbering.
module pal_columns #(
    parameter int unsigned NUM_IN    = 10,
    parameter int unsigned NUM_BIDIR = 6,
    localparam int unsigned NUM_SIG  = NUM_IN + NUM_BIDIR,
    localparam int unsigned NUM_COL  = 2 * NUM_SIG
) (
    input  logic [NUM_IN-1:0]    ded_in,
    input  logic [NUM_BIDIR-1:0] pad_in,
    output logic [NUM_COL-1:0]   cols
);
    logic [NUM_SIG-1:0] sig;

    // Concatenate signals: dedicated inputs low, pad feedback high.
    assign sig = {pad_in, ded_in};

    // Expand each signal into its true and inverted column.
    always_comb begin
        for (int s = 0; s < NUM_SIG; s++) begin
            cols[2*s]   = sig[s];
            cols[2*s+1] = ~sig[s];
        end
    end
endmodule

// File: rtl/pal_and_term.sv
// One product term: AND of all columns whose connection bit is set.
// An empty row yields 1; a row holding both polarities yields 0.
module pal_and_term #(
    parameter int unsigned NUM_COL = 32
) (
    input  logic [NUM_COL-1:0] row,
    input  logic [NUM_COL-1:0] cols,
    output logic               term
);
    // Unconnected columns are forced true so only connected ones matter.
    assign term = &(cols | ~row);
endmodule

// File: rtl/pal_out_cell.sv
// Output cell: the group's first term becomes the enable, the rest are
// ORed through the fixed gate and inverted. Assumes TPO >= 2.
module pal_out_cell #(
    parameter int unsigned TPO = 8
) (
    input  logic [TPO-1:0] terms,
    output logic           val,
    output logic           en
);
    // Enable term straight through.
    assign en  = terms[0];
    // Fixed OR of the sum terms, active-low at the pin.
    assign val = ~(|terms[TPO-1:1]);
endmodule

// File: rtl/pal_sop_array.sv
// Top: programmable AND array with fixed OR outputs and per-pin enable terms.
// Assumes fuse_map is static during operation and that pad_in carries the
// resolved pin level (driven value when enabled, external level otherwise).
module pal_sop_array
    import pal_pkg::*;
#(
    parameter int unsigned NUM_IN    = PAL_DED_IN,
    parameter int unsigned NUM_BIDIR = PAL_BIDIR,
    parameter int unsigned NUM_OUT   = PAL_OUTS,
    parameter int unsigned TPO       = PAL_TPO,
    localparam int unsigned NUM_COL  = 2 * (NUM_IN + NUM_BIDIR),
    localparam int unsigned NUM_TERM = NUM_OUT * TPO,
    localparam int unsigned FUSE_W   = NUM_TERM * NUM_COL
) (
    input  logic [FUSE_W-1:0]    fuse_map,
    input  logic [NUM_IN-1:0]    ded_in,
    input  logic [NUM_BIDIR-1:0] pad_in,
    output logic [NUM_OUT-1:0]   out_val,
    output logic [NUM_OUT-1:0]   out_en
);
    logic [NUM_COL-1:0]  cols;
    logic [NUM_TERM-1:0] terms;

    // Build the column pairs from pins.
    pal_columns #(
        .NUM_IN   (NUM_IN),
        .NUM_BIDIR(NUM_BIDIR)
    ) u_cols (
        .ded_in(ded_in),
        .pad_in(pad_in),
        .cols  (cols)
    );

    // One AND gate per product term.
    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        pal_and_term #(.NUM_COL(NUM_COL)) u_term (
            .row (fuse_map[row_lsb(t, NUM_COL) +: NUM_COL]),
            .cols(cols),
            .term(terms[t])
        );
    end

    // One output cell per output group.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        pal_out_cell #(.TPO(TPO)) u_cell (
            .terms(terms[group_lsb(o, TPO) +: TPO]),
            .val  (out_val[o]),
            .en   (out_en[o])
        );
    end
endmodule

// File: rtl/pal_sop_array_chk.sv
// Checker: relates the connection map to the output buses on every input
// change. Bound to the top; reads only its ports.
module pal_sop_array_chk #(
    parameter int unsigned NUM_IN    = 10,
    parameter int unsigned NUM_BIDIR = 6,
    parameter int unsigned NUM_OUT   = 8,
    parameter int unsigned TPO       = 8,
    localparam int unsigned NUM_COL  = 2 * (NUM_IN + NUM_BIDIR),
    localparam int unsigned FUSE_W   = NUM_OUT * TPO * NUM_COL
) (
    input logic [FUSE_W-1:0]    fuse_map,
    input logic [NUM_IN-1:0]    ded_in,
    input logic [NUM_BIDIR-1:0] pad_in,
    input logic [NUM_OUT-1:0]   out_val,
    input logic [NUM_OUT-1:0]   out_en
);
    // True when a row connects both polarities of some signal.
    function automatic logic has_pair(input logic [NUM_COL-1:0] r);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < NUM_COL / 2; s++) hit |= r[2*s] & r[2*s+1];
        return hit;
    endfunction

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
        // Per-output map checks against both output buses.
        always_comb begin
            logic all_dead;
            logic any_open;
            all_dead = 1'b1;
            any_open = 1'b0;
            for (int k = 1; k < TPO; k++) begin
                all_dead &= has_pair(fuse_map[(o*TPO+k)*NUM_COL +: NUM_COL]);
                any_open |= (fuse_map[(o*TPO+k)*NUM_COL +: NUM_COL] == '0);
            end
            if (!$isunknown({fuse_map, ded_in, pad_in})) begin
                // R4: an unconnected enable term always enables the pin
                if (fuse_map[o*TPO*NUM_COL +: NUM_COL] == '0)
                    a_r4_open_enable: assert (out_en[o])
                        else $error("R4 open enable term did not enable output %0d", o);
                // R3: a contradictory enable term never enables the pin
                if (has_pair(fuse_map[o*TPO*NUM_COL +: NUM_COL]))
                    a_r3_dead_enable: assert (!out_en[o])
                        else $error("R3 dead enable term enabled output %0d", o);
                // R5: any open sum term pulls the active-low output low
                if (any_open)
                    a_r5_open_sum: assert (!out_val[o])
                        else $error("R5 open sum term left output %0d high", o);
                // R3: all sum terms dead leaves the output high
                if (all_dead && !any_open)
                    a_r3_dead_sum: assert (out_val[o])
                        else $error("R3 dead sum terms drove output %0d low", o);
            end
        end
    end

    // R7: known inputs always give known outputs
    always_comb begin
        if (!$isunknown({fuse_map, ded_in, pad_in}))
            a_r7_known_out: assert (!$isunknown({out_val, out_en}))
                else $error("R7 outputs unknown with known inputs");
    end
endmodule

bind pal_sop_array pal_sop_array_chk #(
    .NUM_IN   (NUM_IN),
    .NUM_BIDIR(NUM_BIDIR),
    .NUM_OUT  (NUM_OUT),
    .TPO      (TPO)
) i_chk (
    .fuse_map(fuse_map),
    .ded_in  (ded_in),
    .pad_in  (pad_in),
    .out_val (out_val),
    .out_en  (out_en)
);

// File: tb/test_pal_sop_array.sv
// Bench: drives maps and pin vectors, evaluates the map behaviourally and
// compares both output buses once per clock.
module test_pal_sop_array;
    localparam int NI = 10, NB = 6, NO = 8, TP = 8;
    localparam int NS = NI + NB, NC = 2 * NS, NT = NO * TP, FW = NT * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] fuse_map = '1;
    logic [NI-1:0] ded_in = '0;
    logic [NB-1:0] pad_in = '0;
    logic [NO-1:0] out_val, out_en;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pal_sop_array i_pal_sop_array (
        .fuse_map(fuse_map), .ded_in(ded_in), .pad_in(pad_in),
        .out_val(out_val), .out_en(out_en)
    );

    // Reference: walk every term, kill it on any connected literal that is false.
    function automatic bit [2*NO-1:0] model(input logic [FW-1:0] fm,
                                            input logic [NI-1:0] d,
                                            input logic [NB-1:0] p);
        bit [NO-1:0] v, e;
        for (int o = 0; o < NO; o++) begin
            bit any;
            any = 0;
            for (int k = 0; k < TP; k++) begin
                bit tv;
                tv = 1;
                for (int s = 0; s < NS; s++) begin
                    bit lvl;
                    lvl = (s < NI) ? d[s] : p[s-NI];
                    if (fm[(o*TP+k)*NC + 2*s]   && !lvl) tv = 0;
                    if (fm[(o*TP+k)*NC + 2*s+1] &&  lvl) tv = 0;
                end
                if (k == 0) e[o] = tv;
                else if (tv) any = 1;
            end
            v[o] = !any;
        end
        return {e, v};
    endfunction

    task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_row(input int term, input logic [NC-1:0] r);
        fuse_map[term*NC +: NC] = r;
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(input logic [NI-1:0] d, input logic [NB-1:0] p);
        @(posedge clk); #1;
        ded_in = d; pad_in = p;
        @(negedge clk);
    endtask

    task automatic cmp_model(input string tag);
        bit [2*NO-1:0] m;
        m = model(fuse_map, ded_in, pad_in);
        check({tag, " en"}, out_en, m[2*NO-1:NO]);
        check({tag, " val"}, out_val, m[NO-1:0]);
    endtask

    initial begin
        logic [NO-1:0] first_v, first_e;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R3: intact map, several input patterns
        apply('0, '0);
        check("R3 virgin en", out_en, 8'h00);
        check("R3 virgin val", out_val, 8'hFF);
        apply(10'h3FF, 6'h3F);
        check("R3 virgin en ones", out_en, 8'h00);
        check("R3 virgin val ones", out_val, 8'hFF);

        // R5 and R1: all rows open, every term true
        fuse_map = '0;
        apply(10'h155, 6'h2A);
        check("R5 open en", out_en, 8'hFF);
        check("R5 open val", out_val, 8'h00);

        // Directed map on a dead background
        fuse_map = '1;
        set_row(24, 32'h0000_0010);   // out3 enable = ded2
        set_row(25, 32'h0000_0009);   // out3 sum = ded0 & ~ded1
        set_row(0,  32'h0000_0000);   // out0 always enabled
        set_row(1,  32'h0010_0000);   // out0 sum = pad0
        set_row(8,  32'h0000_0000);   // out1 always enabled
        set_row(9,  32'h0008_0000);   // out1 sum = ~ded9
        set_row(56, 32'h8000_0000);   // out7 enable = ~pad5

        apply(10'h000, 6'h00);
        check("R4 enables v0", out_en, 8'h83);
        check("R2 values v0", out_val, 8'hFD);
        // R6: pad0 read back while its pin (out1) is enabled
        apply(10'h001, 6'h01);
        check("R6 enables v1", out_en, 8'h83);
        check("R6 values v1", out_val, 8'hF4);
        apply(10'h207, 6'h20);
        check("R4 enables v2", out_en, 8'h0B);
        check("R1 values v2", out_val, 8'hFF);
        cmp_model("R2 model v2");

        // R7: same vector after different history gives same result
        apply(10'h001, 6'h01);
        first_v = out_val; first_e = out_en;
        apply(10'h3FE, 6'h3E);
        cmp_model("R7 between");
        apply(10'h001, 6'h01);
        check("R7 repeat val", out_val, first_v);
        check("R7 repeat en", out_en, first_e);

        // R1/R4/R5/R6: random sparse maps against the model
        for (int m = 0; m < 12; m++) begin
            for (int t = 0; t < NT; t++)
                set_row(t, NC'($urandom & $urandom & $urandom & $urandom));
            for (int n = 0; n < 25; n++) begin
                apply(NI'($urandom), NB'($urandom));
                cmp_model("R1 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule